// File: doc/BRIEF.md
# Port Controller Alert and Interrupt Unit

This block keeps the event flags of a USB Type-C port controller and turns them into an interrupt for the host. Event sources inside the controller raise single-cycle pulses. Each pulse sets one bit of a 16-bit alert register. The host reads that register over a byte-wide register bus. It acknowledges an event by writing a one to the bit. A bit written with zero keeps its value. A 16-bit alert mask decides which flags may interrupt. The active-low, level-sensitive interrupt stays asserted for as long as any flag is both set and enabled.

An 8-bit power-status mask register also sits on the same bus. It comes out of reset as all ones. A host that reads all ones there knows that the controller has been through a reset since the host last programmed it. Each 16-bit register takes two consecutive byte addresses, with the low byte at the even address. Reads have no side effects. The upper half of the address space belongs to vendor extensions. This block returns zero there and ignores writes.

Top module: `alrt_irq_unit`

## Requirements
- R1: After reset, the alert register (0x10/0x11) and the alert mask (0x12/0x13) read 0x00. The power-status mask (0x14) reads 0xFF, and irq_n is high.
- R2: A pulse on evt_i[k] sets alert bit k. The bit map is: 0 CC status change, 1 power status change, 2 message received, 3 hard reset received, 4 transmit failed, 5 transmit discarded, 6 transmit succeeded, 7 high voltage alarm, 8 low voltage alarm, 9 fault, 10 receive buffer overflow, 11 VBUS disconnect. Alert bits 12 to 15 always read zero.
- R3: A write of data D to 0x10 clears alert bits [7:0] where D has a one. A write of D to 0x11 does the same for bits [15:8]. Bits written with zero are unchanged, and writing 0xFF to both bytes clears every flag.
- R4: The message-received flag (bit 2) stays set until a write to 0x10 carries a one in bit 2. Writes that clear other flags, in either byte, leave it set.
- R5: If an event pulse and a write-one clear hit the same alert bit in the same cycle, the bit ends up set.
- R6: irq_n is low exactly when some alert bit and its mask bit are both one. It follows changes to either register in the cycle after the clock edge that updates them.
- R7: The alert mask is read/write, little-endian: bits [7:0] at 0x12 and bits [15:8] at 0x13.
- R8: The power-status mask at 0x14 is an ordinary read/write byte and changes only when 0x14 is written.
- R9: Addresses 0x80 to 0xFF and unmapped addresses below 0x80 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_EVT (12) | Single-cycle event pulses, one per alert bit |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_we | input | 1 | Write strobe for one byte, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
The assertions assume the following about the inputs:
- A write lasts exactly one cycle, and the address is stable while bus_we is high.
- The event inputs are clean, synchronous pulses, so a flag that falls can only have been cleared by a write.

The interrupt check after an event also assumes no write occurs in that same cycle, because a write could change the mask. The bench drives every input on the falling edge and raises each event and each write for exactly one cycle. It combines them deliberately only in the same-cycle priority scenario.

// File: rtl/alrt_pkg.sv
// Package: shared constants and types of the alert interrupt unit.
// Assumes an 8-bit byte lane on the register bus.
package alrt_pkg;
    localparam int BYTE_W      = 8;
    localparam int ALERT_W     = 16;
    localparam int NUM_EVT     = 12;
    localparam int ADDR_W      = 8;
    localparam int ADDR_ALERT  = 'h10;
    localparam int ADDR_AMASK  = 'h12;
    localparam int ADDR_PMASK  = 'h14;
    localparam int VENDOR_BASE = 'h80;
    localparam int PMASK_RST   = 'hFF;
    localparam int BIT_RX_MSG  = 2;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_ALERT = 2'd1,
        SEL_AMASK = 2'd2,
        SEL_PMASK = 2'd3
    } rsel_e;
endpackage

// File: rtl/alrt_decode.sv
// Module: address decoder. Turns a byte address and write strobe into
// per-lane write enables and a read selection.
// Assumes register bases lie below VENDOR_BASE; vendor space decodes to nothing.
module alrt_decode
    import alrt_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int NB    = ALERT_W / BYTE_W,
    parameter int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [AW-1:0]    addr,
    input  logic             we,
    output logic [NB-1:0]    alert_wr,
    output logic [NB-1:0]    amask_wr,
    output logic             pmask_wr,
    output rsel_e            rsel,
    output logic [SEL_W-1:0] rbyte
);
    logic          in_std;
    logic [NB-1:0] hit_alert;
    logic [NB-1:0] hit_amask;
    logic          hit_pmask;

    // Standard (non-vendor) address window.
    assign in_std = (addr < AW'(VENDOR_BASE));

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_lane
            // Per-lane match for the two 16-bit registers.
            assign hit_alert[b] = in_std && (addr == AW'(ADDR_ALERT + b));
            assign hit_amask[b] = in_std && (addr == AW'(ADDR_AMASK + b));
        end
    endgenerate

    assign hit_pmask = in_std && (addr == AW'(ADDR_PMASK));

    // Write strobes gate the hits with the bus write enable.
    assign alert_wr = we ? hit_alert : '0;
    assign amask_wr = we ? hit_amask : '0;
    assign pmask_wr = we && hit_pmask;

    // Read selection: which register and which byte lane drive read data.
    always_comb begin
        rsel  = SEL_NONE;
        rbyte = '0;
        for (int i = 0; i < NB; i++) begin
            if (hit_alert[i]) begin
                rsel  = SEL_ALERT;
                rbyte = SEL_W'(i);
            end
            if (hit_amask[i]) begin
                rsel  = SEL_AMASK;
                rbyte = SEL_W'(i);
            end
        end
        if (hit_pmask) rsel = SEL_PMASK;
    end
endmodule

// File: rtl/alrt_flags.sv
// Module: alert flag register. Event pulses set bits; byte writes clear
// the bits written with one. Set beats clear in the same cycle.
// Assumes evt pulses are synchronous; bits at and above NEVT are never set.
module alrt_flags
    import alrt_pkg::*;
#(
    parameter int W    = ALERT_W,
    parameter int NEVT = NUM_EVT,
    parameter int NB   = W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NEVT-1:0]   evt,
    input  logic [NB-1:0]     wr_lane,
    input  logic [BYTE_W-1:0] wdata,
    output logic [W-1:0]      alert_q
);
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;
    logic         past_ok;

    // Zero-extend events to the register width; reserved bits stay clear.
    assign set_v = {{(W-NEVT){1'b0}}, evt};

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_clr
            // Write-one-clear mask for this byte lane.
            assign clr_v[b*BYTE_W +: BYTE_W] = wr_lane[b] ? wdata : '0;
        end
    endgenerate

    // Flag state: clear written ones, then apply new events (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) alert_q <= '0;
        else        alert_q <= (alert_q & ~clr_v) | set_v;
    end

    // Marks that one post-reset edge has passed, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((alert_q & $past(set_v)) == $past(set_v))); // R5
    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ((($past(alert_q) & ~alert_q) & ~$past(clr_v)) == '0)); // R3
    AST_RX_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        ($past(alert_q[BIT_RX_MSG]) && !alert_q[BIT_RX_MSG]) |-> $past(clr_v[BIT_RX_MSG])); // R4
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (alert_q[W-1:NEVT] == '0)); // R2
endmodule

// File: rtl/alrt_mask_regs.sv
// Module: alert mask (byte-lane writable) and power-status mask registers.
// Assumes at most one lane strobe per cycle from the decoder.
module alrt_mask_regs
    import alrt_pkg::*;
#(
    parameter int W    = ALERT_W,
    parameter int NB   = W / BYTE_W,
    parameter int PRST = PMASK_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     amask_wr,
    input  logic              pmask_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [W-1:0]      amask_q,
    output logic [BYTE_W-1:0] pmask_q
);
    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_lane
            // One byte of the alert mask; resets to disabled.
            always_ff @(posedge clk) begin
                if (!rst_n)           amask_q[b*BYTE_W +: BYTE_W] <= '0;
                else if (amask_wr[b]) amask_q[b*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    endgenerate

    // Power-status mask; resets to all ones as a reset marker for the host.
    always_ff @(posedge clk) begin
        if (!rst_n)        pmask_q <= BYTE_W'(PRST);
        else if (pmask_wr) pmask_q <= wdata;
    end

    AST_PMASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pmask_wr |=> $stable(pmask_q)); // R8
    AST_AMASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (amask_wr == '0) |=> $stable(amask_q)); // R7
endmodule

// File: rtl/alrt_irq_unit.sv
// Module: top of the alert interrupt unit. Ties the decoder, flags and mask
// registers together, muxes read data and drives the level interrupt.
// Assumes single-cycle byte writes with a stable address; reads are free of side effects.
module alrt_irq_unit
    import alrt_pkg::*;
#(
    parameter int ADDR_BITS = ADDR_W,
    parameter int EVT_N     = NUM_EVT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_N-1:0]     evt_i,
    input  logic [ADDR_BITS-1:0] bus_addr,
    input  logic                 bus_we,
    input  logic [BYTE_W-1:0]    bus_wdata,
    output logic [BYTE_W-1:0]    bus_rdata,
    output logic                 irq_n
);
    localparam int NB    = ALERT_W / BYTE_W;
    localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1;

    logic [NB-1:0]      alert_wr;
    logic [NB-1:0]      amask_wr;
    logic               pmask_wr;
    rsel_e              rsel;
    logic [SEL_W-1:0]   rbyte;
    logic [ALERT_W-1:0] alert_q;
    logic [ALERT_W-1:0] amask_q;
    logic [BYTE_W-1:0]  pmask_q;

    alrt_decode #(.AW(ADDR_BITS), .NB(NB), .SEL_W(SEL_W)) u_decode (
        .addr     (bus_addr),
        .we       (bus_we),
        .alert_wr (alert_wr),
        .amask_wr (amask_wr),
        .pmask_wr (pmask_wr),
        .rsel     (rsel),
        .rbyte    (rbyte)
    );

    alrt_flags #(.W(ALERT_W), .NEVT(EVT_N), .NB(NB)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_i),
        .wr_lane (alert_wr),
        .wdata   (bus_wdata),
        .alert_q (alert_q)
    );

    alrt_mask_regs #(.W(ALERT_W), .NB(NB), .PRST(PMASK_RST)) u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .amask_wr (amask_wr),
        .pmask_wr (pmask_wr),
        .wdata    (bus_wdata),
        .amask_q  (amask_q),
        .pmask_q  (pmask_q)
    );

    // Read data mux: selected register byte, zero for anything unmapped.
    always_comb begin
        case (rsel)
            SEL_ALERT: bus_rdata = alert_q[{rbyte, 3'b000} +: BYTE_W];
            SEL_AMASK: bus_rdata = amask_q[{rbyte, 3'b000} +: BYTE_W];
            SEL_PMASK: bus_rdata = pmask_q;
            default:   bus_rdata = '0;
        endcase
    end

    // Level interrupt: low while any enabled flag is set.
    assign irq_n = ~|(alert_q & amask_q);

    AST_IRQ_AFTER_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_i & amask_q[EVT_N-1:0])) && !bus_we) |=> !irq_n); // R6
    AST_VENDOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr >= ADDR_BITS'(VENDOR_BASE)) |=> ($stable(amask_q) && $stable(pmask_q))); // R9
    AST_VENDOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_BITS'(VENDOR_BASE)) |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/alrt_irq_unit_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module alrt_irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_n;
    int          errors = 0;
    int          checks = 0;

    always #5 clk = ~clk;

    alrt_irq_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] v);
        @(negedge clk);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic clear_all();
        wr(8'h10, 8'hFF);
        wr(8'h11, 8'hFF);
    endtask

    task automatic t_reset();
        rd_chk("R1 alert lo", 8'h10, 8'h00);
        rd_chk("R1 alert hi", 8'h11, 8'h00);
        rd_chk("R1 mask lo", 8'h12, 8'h00);
        rd_chk("R1 mask hi", 8'h13, 8'h00);
        rd_chk("R1 pmask", 8'h14, 8'hFF);
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_set();
        pulse(12'h001);
        rd_chk("R2 bit0", 8'h10, 8'h01);
        pulse(12'h800);
        rd_chk("R2 bit11", 8'h11, 8'h08);
        pulse(12'hFFF);
        rd_chk("R2 all lo", 8'h10, 8'hFF);
        rd_chk("R2 reserved hi", 8'h11, 8'h0F);
        chk("R6 masked off", {7'b0, irq_n}, 8'h01);
        clear_all();
        rd_chk("R3 clear all lo", 8'h10, 8'h00);
        rd_chk("R3 clear all hi", 8'h11, 8'h00);
    endtask

    task automatic t_w1c();
        pulse(12'hFFF);
        wr(8'h10, 8'h30);
        rd_chk("R3 partial lo", 8'h10, 8'hCF);
        rd_chk("R3 hi untouched", 8'h11, 8'h0F);
        wr(8'h11, 8'h01);
        rd_chk("R3 partial hi", 8'h11, 8'h0E);
        clear_all();
    endtask

    task automatic t_rx();
        pulse(12'h005);
        wr(8'h10, 8'hFB);
        rd_chk("R4 rx kept", 8'h10, 8'h04);
        wr(8'h11, 8'hFF);
        rd_chk("R4 rx kept hi write", 8'h10, 8'h04);
        wr(8'h10, 8'h04);
        rd_chk("R4 rx cleared", 8'h10, 8'h00);
    endtask

    task automatic t_prio();
        pulse(12'h010);
        @(negedge clk);
        evt_i = 12'h012; bus_addr = 8'h10; bus_wdata = 8'h10; bus_we = 1'b1;
        @(negedge clk);
        evt_i = '0; bus_we = 1'b0;
        rd_chk("R5 set wins", 8'h10, 8'h12);
        clear_all();
    endtask

    task automatic t_irq();
        wr(8'h12, 8'h40);
        rd_chk("R7 mask lo", 8'h12, 8'h40);
        pulse(12'h020);
        chk("R6 unmasked flag", {7'b0, irq_n}, 8'h01);
        pulse(12'h040);
        chk("R6 masked flag", {7'b0, irq_n}, 8'h00);
        wr(8'h10, 8'h40);
        chk("R6 release on clear", {7'b0, irq_n}, 8'h01);
        wr(8'h13, 8'h08);
        rd_chk("R7 mask hi", 8'h13, 8'h08);
        pulse(12'h800);
        chk("R6 hi byte flag", {7'b0, irq_n}, 8'h00);
        wr(8'h13, 8'h00);
        chk("R6 release on mask", {7'b0, irq_n}, 8'h01);
        rd_chk("R7 mask lo kept", 8'h12, 8'h40);
        clear_all();
    endtask

    task automatic t_pmask();
        wr(8'h14, 8'h5A);
        rd_chk("R8 pmask write", 8'h14, 8'h5A);
        wr(8'h12, 8'h41);
        rd_chk("R8 pmask kept", 8'h14, 8'h5A);
        wr(8'h14, 8'hFF);
        rd_chk("R8 pmask restore", 8'h14, 8'hFF);
    endtask

    task automatic t_vendor();
        wr(8'h92, 8'hFF);
        wr(8'h80, 8'h00);
        wr(8'h94, 8'h00);
        wr(8'h15, 8'h00);
        rd_chk("R9 mask unchanged", 8'h12, 8'h41);
        rd_chk("R9 pmask unchanged", 8'h14, 8'hFF);
        pulse(12'h001);
        wr(8'h90, 8'hFF);
        rd_chk("R9 alert unchanged", 8'h10, 8'h01);
        chk("R9 irq still low", {7'b0, irq_n}, 8'h00);
        rd_chk("R9 vendor read", 8'h90, 8'h00);
        rd_chk("R9 unmapped read", 8'h15, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_w1c();
        t_rx();
        t_prio();
        t_irq();
        t_pmask();
        t_vendor();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule